// File: doc/BRIEF.md
# Dual External Interrupt Request Conditioner

This block takes two external interrupt request pins and turns them into one prioritised request for a downstream interrupt arbiter. Each pin first passes through a two-flop synchroniser. It then becomes a pending request in one of two ways. In rising-edge mode, a low-to-high transition sets a pending latch. In level mode, the synchronised pin is used directly as the request while it is high. Either way, the pin is expected to stay high until the processor acknowledges the request.

Each source has a 16-bit control word. The word holds the sensing mode, a mask bit and a 3-bit priority code. A third address gives a shared mask view that holds both mask bits. Writing either view changes the same mask storage. The block presents the unmasked pending source with the numerically lowest priority code, together with that source's fixed type number (0Eh or 0Fh) and its priority code. An acknowledge that carries a type number clears that source's pending state.

Top module: `ext_irq_pair`

## Requirements
- R1: After reset, both control words read 000Fh (edge mode, masked, priority 7), the shared mask view reads 0003h, and `req_valid_o` is low.
- R2: Control word layout: bit 4 selects level mode when 1, bit 3 is the mask, and bits 2..0 are the priority. Bits 15..5 always read 0, and writes to them are ignored.
- R3: Address 0 is the control word for source 0Eh, address 1 is the control word for source 0Fh, and address 2 is the shared mask view (bit 0 is the 0Eh mask, bit 1 is the 0Fh mask). A write to either a control word or the mask view is visible in the other view.
- R4: In edge mode, a rising pin is presented as a request on the third clock edge after the pin rises. The request stays pending after the pin falls, until it is acknowledged.
- R5: In level mode, the request follows the synchronised pin. It appears on the second clock edge after the pin rises and disappears on the second clock edge after the pin falls.
- R6: A masked source is never presented. When the mask is cleared, a pending edge latch is presented from the next cycle on.
- R7: When both sources are eligible, the one with the lower priority code is presented. When the codes are equal, source 0Eh wins.
- R8: `req_type_o` carries 0Eh or 0Fh for the presented source, and `req_prio_o` carries that source's priority code.
- R9: An acknowledge whose type matches an edge-mode source clears its latch on that clock edge. An acknowledge with any other type has no effect. A rising edge detected in the same cycle as the acknowledge keeps the source pending.
- R10: In level mode, the source is withheld for the one cycle after its acknowledge. It is presented again afterwards if the pin is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 2 | External request pins (bit 0 = source 0Eh, bit 1 = source 0Fh) |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data (combinational from the address) |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_type_i | input | 8 | Type number being acknowledged |
| req_valid_o | output | 1 | A source is presented |
| req_type_o | output | 8 | Type number of the presented source |
| req_prio_o | output | 3 | Priority code of the presented source |

## Verification
Two functions can fall in the same cycle: an acknowledge of a source, and detection of a new event for the same or the other source.

The bench provokes two such cases. In the first, an acknowledge of the level-mode 0Eh source arrives while 0Fh holds a latched edge. Here 0Fh must take over for exactly one cycle before 0Eh returns. In the second, an acknowledge of 0Fh is timed to land on the very edge where its fresh rising edge is latched, and the source must stay pending.

A scoreboard holds the expected request or read value for each cycle. It compares that value against the ports just after the clock edge that should produce it.

// File: rtl/ext_irq_pair.sv
module ext_irq_pair #(
  parameter int DATA_W     = 16,
  parameter int PRIO_W     = 3,
  parameter int TYPE_W     = 8,
  parameter int SYNC_DEPTH = 2,
  parameter logic [TYPE_W-1:0] TYPE_LO = 8'h0E,
  parameter logic [TYPE_W-1:0] TYPE_HI = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        irq_pin_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              ack_valid_i,
  input  logic [TYPE_W-1:0] ack_type_i,
  output logic              req_valid_o,
  output logic [TYPE_W-1:0] req_type_o,
  output logic [PRIO_W-1:0] req_prio_o
);
  localparam int NSRC  = 2;
  localparam int FLD_W = PRIO_W + 2;
  localparam logic [1:0] ADDR_MASK = 2'd2;

  logic [NSRC-1:0]   lvl_mode, msk;
  logic [PRIO_W-1:0] prio [NSRC];
  logic [NSRC-1:0]   s_q, s_d, rise, ack_hit, edge_pend, ack_blk, pending, elig;
  logic [TYPE_W-1:0] src_type [NSRC];
  logic              pick_hi;
  logic              unused_wdata;

  assign src_type[0]  = TYPE_LO;
  assign src_type[1]  = TYPE_HI;
  assign unused_wdata = ^cfg_wdata_i[DATA_W-1:FLD_W];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic [SYNC_DEPTH-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sync_q <= '0;
        s_d[i] <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_DEPTH-2:0], irq_pin_i[i]};
        s_d[i] <= sync_q[SYNC_DEPTH-1];
      end

    assign s_q[i]     = sync_q[SYNC_DEPTH-1];
    assign rise[i]    = s_q[i] & ~s_d[i];
    assign ack_hit[i] = ack_valid_i && (ack_type_i == src_type[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        lvl_mode[i] <= 1'b0;
        prio[i]     <= '1;
      end else if (cfg_we_i && cfg_addr_i == 2'(i)) begin
        lvl_mode[i] <= cfg_wdata_i[PRIO_W+1];
        prio[i]     <= cfg_wdata_i[PRIO_W-1:0];
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        msk[i] <= 1'b1;
      else if (cfg_we_i && cfg_addr_i == 2'(i))
        msk[i] <= cfg_wdata_i[PRIO_W];
      else if (cfg_we_i && cfg_addr_i == ADDR_MASK)
        msk[i] <= cfg_wdata_i[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        edge_pend[i] <= 1'b0;
        ack_blk[i]   <= 1'b0;
      end else begin
        ack_blk[i] <= ack_hit[i];
        if (lvl_mode[i])     edge_pend[i] <= 1'b0;
        else if (rise[i])    edge_pend[i] <= 1'b1;
        else if (ack_hit[i]) edge_pend[i] <= 1'b0;
      end

    assign pending[i] = lvl_mode[i] ? (s_q[i] & ~ack_blk[i]) : edge_pend[i];
    assign elig[i]    = pending[i] & ~msk[i];

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pend[i] && !ack_hit[i] && !lvl_mode[i] |=> edge_pend[i]); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit[i] && !lvl_mode[i] && !rise[i] |=> !edge_pend[i]); // R9

    AST_LEVEL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit[i] && lvl_mode[i] |=> !(req_valid_o && req_type_o == src_type[i])); // R10

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o && req_type_o == src_type[i] |-> !msk[i]); // R6
  end

  assign pick_hi     = elig[1] & (~elig[0] | (prio[1] < prio[0]));
  assign req_valid_o = |elig;
  assign req_type_o  = !req_valid_o ? '0 : (pick_hi ? TYPE_HI : TYPE_LO);
  assign req_prio_o  = !req_valid_o ? '0 : (pick_hi ? prio[1] : prio[0]);

  always_comb begin
    cfg_rdata_o = '0;
    case (cfg_addr_i)
      2'd0:      cfg_rdata_o[FLD_W-1:0] = {lvl_mode[0], msk[0], prio[0]};
      2'd1:      cfg_rdata_o[FLD_W-1:0] = {lvl_mode[1], msk[1], prio[1]};
      ADDR_MASK: cfg_rdata_o[NSRC-1:0]  = msk;
      default:   cfg_rdata_o = '0;
    endcase
  end

  AST_PRIO_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    elig == 2'b11 |-> req_prio_o <= prio[0] && req_prio_o <= prio[1]); // R7

  AST_TYPE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_type_o == TYPE_LO || req_type_o == TYPE_HI)); // R8
endmodule

// File: tb/ext_irq_pair_tb.sv
module ext_irq_pair_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  irq_pin = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  logic        ack_valid = 1'b0;
  logic [7:0]  ack_type = '0, req_type;
  logic        req_valid;
  logic [2:0]  req_prio;

  always #2 clk = ~clk;

  ext_irq_pair dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin_i(irq_pin),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .ack_valid_i(ack_valid), .ack_type_i(ack_type),
    .req_valid_o(req_valid), .req_type_o(req_type), .req_prio_o(req_prio)
  );

  typedef struct {
    bit          is_rd;
    logic [15:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      bit ok;
      it = q.pop_front();
      n_chk++;
      if (it.is_rd) begin
        act = cfg_rdata;
        ok  = (act == it.exp);
      end else begin
        act = {4'b0, req_valid, req_prio, req_type};
        ok  = it.exp[11] ? (act == it.exp) : !req_valid;
      end
      if (!ok) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic chk_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    cfg_addr = a;
    it.is_rd = 1'b1; it.exp = e; it.tag = tag;
    q.push_back(it);
    step();
  endtask

  task automatic chk_req(input bit v, input logic [7:0] t, input logic [2:0] p, input string tag);
    item_t it;
    it.is_rd = 1'b0; it.exp = {4'b0, v, p, t}; it.tag = tag;
    q.push_back(it);
    step();
  endtask

  task automatic ack(input logic [7:0] t, input bit v, input logic [7:0] et,
                     input logic [2:0] ep, input string tag);
    ack_valid = 1'b1; ack_type = t;
    chk_req(v, et, ep, tag);
    ack_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    chk_rd(2'd0, 16'h000F, "R1 ctrl0 reset");
    chk_rd(2'd1, 16'h000F, "R1 ctrl1 reset");
    chk_rd(2'd2, 16'h0003, "R1 mask view reset");
    chk_req(0, 8'h00, 3'd0, "R1 no request");

    wr(2'd0, 16'hFFF2);
    chk_rd(2'd0, 16'h0012, "R2 fields stored reserved zero");
    chk_rd(2'd2, 16'h0002, "R3 mask view after ctrl write");
    wr(2'd2, 16'h0001);
    chk_rd(2'd0, 16'h001A, "R3 ctrl0 after mask view write");
    wr(2'd2, 16'h0000);
    chk_rd(2'd1, 16'h0007, "R3 ctrl1 unmasked via view");

    irq_pin[0] = 1'b1; step();
    chk_req(1, 8'h0E, 3'd2, "R5 R8 level request");
    irq_pin[0] = 1'b0; step();
    chk_req(0, 8'h00, 3'd0, "R5 level drops");

    irq_pin[1] = 1'b1; step(); step();
    chk_req(1, 8'h0F, 3'd7, "R4 edge latched");
    irq_pin[1] = 1'b0; step(); step(); step();
    chk_req(1, 8'h0F, 3'd7, "R4 latch survives pin low");
    ack(8'h0D, 1, 8'h0F, 3'd7, "R9 foreign ack ignored");
    ack(8'h0F, 0, 8'h00, 3'd0, "R9 ack clears latch");

    irq_pin = 2'b11; step(); step();
    chk_req(1, 8'h0E, 3'd2, "R7 lower code wins");
    wr(2'd1, 16'h0001);
    chk_req(1, 8'h0F, 3'd1, "R7 R8 other source lower");
    wr(2'd0, 16'h0011);
    chk_req(1, 8'h0E, 3'd1, "R7 tie goes to 0Eh");

    ack(8'h0E, 1, 8'h0F, 3'd1, "R10 level withheld after ack");
    chk_req(1, 8'h0E, 3'd1, "R10 level reasserts");

    wr(2'd2, 16'h0003);
    chk_req(0, 8'h00, 3'd0, "R6 both masked");
    wr(2'd2, 16'h0001);
    chk_req(1, 8'h0F, 3'd1, "R6 latched edge shown on unmask");
    wr(2'd2, 16'h0000);
    chk_req(1, 8'h0E, 3'd1, "R6 R7 both unmasked tie");

    irq_pin[0] = 1'b0; step(); step();
    chk_req(1, 8'h0F, 3'd1, "R5 level gone edge remains");
    ack(8'h0F, 0, 8'h00, 3'd0, "R9 cleared");
    irq_pin[1] = 1'b0; step(); step(); step();
    irq_pin[1] = 1'b1; step(); step();
    ack(8'h0F, 1, 8'h0F, 3'd1, "R9 edge and ack same cycle");
    irq_pin[1] = 1'b0;
    ack(8'h0F, 0, 8'h00, 3'd0, "R9 second ack clears");

    wr(2'd1, 16'hFFE0);
    chk_rd(2'd1, 16'h0000, "R2 reserved bits ignored");

    step(); step();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule